// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block widens a controller's set of output pins using only a few wires. Bits arrive one per enabled clock on a serial data input and pass through an internal chain of shift flops. A separate holding register drives the parallel outputs. That register updates only when a load strobe is given, so the pins stay steady while the next word is shifted in.

The last flop of the chain is brought out as a serial cascade output. Several expanders can therefore be daisy-chained to give more outputs. Everything runs on one clock. Shift, load, the clear of the shift chain and the clear of the outputs are all synchronous enables. Clearing the shift chain leaves the outputs alone. The outputs are cleared only by their own clear input.

Top module: `latched_out_expander`

## Requirements
- R1: On a clock edge with `shift_en` high and `rst` low, chain stage 0 takes `ser_in` and each stage k>0 takes the old value of stage k-1. With `shift_en` low, the chain holds its value.
- R2: Chain stage k is presented on `par_out[k]` after a load. A bit applied on the j-th of W consecutive shifts (j = 1..W) therefore appears on `par_out[W-j]`. A word sent most significant bit first lands on `par_out` unchanged.
- R3: `par_out` changes only on an edge where `load` or `out_clr` is high. Shifting alone never changes it.
- R4: On an edge with `load` high and `out_clr` low, the whole chain is copied into `par_out`, and the new value is visible right after that edge.
- R5: When `shift_en` and `load` are high on the same edge, `par_out` receives the chain value from before that edge's shift.
- R6: On an edge with `rst` high, every chain stage becomes 0. This takes priority over `shift_en`, and `ser_out` reads 0 afterwards.
- R7: `rst` does not change `par_out`.
- R8: On an edge with `out_clr` high, `par_out` becomes 0. This takes priority over `load`.
- R9: `ser_out` is the last chain stage (W-1). After W shifts it shows the bit that was applied W shifts earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of the shift chain, active high |
| ser_in | input | 1 | Serial data into chain stage 0 |
| shift_en | input | 1 | Advance the chain by one stage |
| load | input | 1 | Copy the chain into the output register |
| out_clr | input | 1 | Synchronous clear of the output register |
| par_out | output | WIDTH | Registered parallel outputs |
| ser_out | output | 1 | Cascade output, last chain stage |

## Verification
A wrong bit in the shift chain stays hidden at `par_out` until the next load strobe. It shows at `ser_out` only once it has moved to the last stage, which takes up to W shift edges. A wrong bit in the output register shows at `par_out` on the edge that wrote it. The bench therefore checks `par_out` after every edge, checks `ser_out` after every shift, and follows each fully shifted word with a load so that every chain stage is read out at the pins.

// File: rtl/oexp_pkg.sv
package oexp_pkg;
  localparam int DEF_WIDTH = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_CLEAR = 2'd2
  } chain_act_e;
endpackage

// File: rtl/oexp_shift_chain.sv
module oexp_shift_chain
  import oexp_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] chain_q
);
  chain_act_e act;

  always_comb begin
    if (rst)           act = ACT_CLEAR;
    else if (shift_en) act = ACT_SHIFT;
    else               act = ACT_HOLD;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = ser_in;
    end else begin : g_body
      assign nxt = chain_q[i-1];
    end
    always_ff @(posedge clk) begin
      case (act)
        ACT_CLEAR: chain_q[i] <= 1'b0;
        ACT_SHIFT: chain_q[i] <= nxt;
        default:   chain_q[i] <= chain_q[i];
      endcase
    end
  end

  // R1: one stage advance per enabled edge
  p_shift_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain_q == {$past(chain_q[WIDTH-2:0]), $past(ser_in)});
  // R1: idle chain holds
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/oexp_hold_reg.sv
module oexp_hold_reg
  import oexp_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (clr)       q <= '0;
    else if (load) q <= d;
    if (clr) armed <= 1'b1;
  end

  // R3: no update without a strobe
  p_steady_r3: assert property (@(posedge clk) disable iff (clr)
    armed && !load |=> $stable(q));
  // R4: full-word copy in one edge
  p_copy_r4: assert property (@(posedge clk) disable iff (clr)
    load |=> q == $past(d));
endmodule

// File: rtl/latched_out_expander.sv
module latched_out_expander
  import oexp_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             load,
  input  logic             out_clr,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] chain_q;

  oexp_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .chain_q  (chain_q)
  );

  oexp_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk  (clk),
    .clr  (out_clr),
    .load (load),
    .d    (chain_q),
    .q    (par_out)
  );

  assign ser_out = chain_q[LAST];

  // R6: chain empty right after a clear
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> chain_q == '0 && !ser_out);
  // R7: chain clear leaves outputs alone
  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !$past(load) && !$past(out_clr) |-> par_out == $past(par_out));
  // R8: output clear wins over load
  p_oclr_r8: assert property (@(posedge clk) disable iff (rst)
    out_clr |=> par_out == '0);
  // R9: cascade output follows the stage before it
  p_cascade_r9: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ser_out == $past(chain_q[LAST-1]));
  // R5: simultaneous shift and load capture the pre-shift word
  p_preshift_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en && load && !out_clr |=> par_out == $past(chain_q));
endmodule

// File: tb/latched_out_expander_tb.sv
`timescale 1ns/1ps
module latched_out_expander_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, ser_in, shift_en, load, out_clr;
  logic [W-1:0] par_out;
  logic ser_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  latched_out_expander #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
    .load(load), .out_clr(out_clr), .par_out(par_out), .ser_out(ser_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int j = W - 1; j >= 0; j--) begin
      ser_in = w[j]; shift_en = 1'b1; tick();
    end
    shift_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    rst = 1'b1; out_clr = 1'b1; ser_in = 1'b0; shift_en = 1'b0; load = 1'b0;
    #1; tick(); tick();
    rst = 1'b0; out_clr = 1'b0; tick();
    chk("R6 reset ser_out", {7'd0, ser_out}, 8'h00);
    chk("R8 reset par_out", par_out, 8'h00);

    prev = '0;
    for (int w = 0; w < 256; w++) begin
      for (int k = 1; k <= W; k++) begin
        ser_in = w[W-k]; shift_en = 1'b1; tick();
        chk("R3 steady while shifting", par_out, prev);
        if (k < W) chk("R9 cascade", {7'd0, ser_out}, {7'd0, prev[W-1-k]});
        else       chk("R9 cascade", {7'd0, ser_out}, {7'd0, w[W-1]});
      end
      shift_en = 1'b0; load = 1'b1; tick(); load = 1'b0;
      chk("R2 R4 word load", par_out, w[W-1:0]);
      prev = w[W-1:0];
    end

    send_word(8'hA5);
    ser_in = 1'b0; shift_en = 1'b1; load = 1'b1; tick();
    shift_en = 1'b0; load = 1'b0;
    chk("R5 pre-shift capture", par_out, 8'hA5);
    load = 1'b1; tick(); load = 1'b0;
    chk("R1 one stage advance", par_out, 8'h4A);

    for (int t = 0; t < 3; t++) begin
      ser_in = ~ser_in; tick();
    end
    load = 1'b1; tick(); load = 1'b0;
    chk("R1 idle chain holds", par_out, 8'h4A);

    rst = 1'b1; tick(); rst = 1'b0;
    chk("R7 rst keeps outputs", par_out, 8'h4A);
    chk("R6 ser_out after rst", {7'd0, ser_out}, 8'h00);
    load = 1'b1; tick(); load = 1'b0;
    chk("R6 chain cleared", par_out, 8'h00);

    ser_in = 1'b1; shift_en = 1'b1; rst = 1'b1; tick(); tick();
    rst = 1'b0; shift_en = 1'b0; load = 1'b1; tick(); load = 1'b0;
    chk("R6 rst over shift", par_out, 8'h00);

    send_word(8'hFF);
    out_clr = 1'b1; load = 1'b1; tick(); out_clr = 1'b0; load = 1'b0;
    chk("R8 clear over load", par_out, 8'h00);
    load = 1'b1; tick(); load = 1'b0;
    chk("R8 chain survives clear", par_out, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule